// File: doc/BRIEF.md
# Event Interrupt Aggregation Register

This block is a single 32-bit control and status register that gathers ten one-cycle event pulses from a DMA bridge. It drives three level interrupt lines. Every event owns a sticky pending flag and a mask-enable flag. A pending flag is recorded whatever the state of its enable, so software can always poll it. Only the interrupt outputs are gated by the enables.

Software reads the whole register and acknowledges events by writing zero to their pending bits. Writing one to a pending bit changes nothing. Writing zero to an enable bit masks the event.

The events feed the lines unevenly:
- The USB address error drives one line on its own.
- The USB transfer-done event shares a line with the four audio all-done events.
- The four audio half-done events share the third line.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset the register reads 0x00000000 and all three interrupt lines are low.
- R2: An event pulse sets its pending bit on the next clock edge, whether or not the event is enabled. Event 0 (USB done) uses bit 0, event 1 (USB address error) uses bit 1, and audio event n (2..9) uses bit n+14.
- R3: Each enable bit sits 8 positions above the pending bit of its event: bits 8 and 9 for events 0 and 1, and bit n+22 for event n. A write loads all enable bits from the write data.
- R4: A write with 0 in a pending bit clears that bit. A write with 1 in a pending bit leaves it unchanged, so software can never set a pending flag.
- R5: Bits 15:10 and 7:2 always read zero, and writes to them have no effect.
- R6: If an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: Interrupt line 0 is registered. It is high in the cycle after event 1 is both pending and enabled, and it reacts to no other event.
- R8: Interrupt line 1 is registered. It is high in the cycle after any of events 0, 2, 4, 6 or 8 is both pending and enabled.
- R9: Interrupt line 2 is registered. It is high in the cycle after any of events 3, 5, 7 or 9 is both pending and enabled.
- R10: An interrupt line stays high until every contributing event is cleared or masked. It drops one cycle after the last one goes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | One-cycle event pulses, bit n is event n |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register contents |
| irq_o | output | 3 | Level interrupt lines 0..2 |

## Verification
Each event is pulsed alone while it is masked. This separates the pending-bit mapping from the enable gating, and shows that no line moves.

Each event is then pulsed alone while all events are enabled. This shows which single line it reaches, and so tells a misrouted event from a missing one.

Two events of the same group are raised and then cleared one at a time. A line that holds for the remaining event is told apart from one that follows only the last event. Masking alone, without clearing, is also shown to drop the line.

Finally, an all-ones write, a write clearing everything in the same cycle as an event, and a write to the reserved bits separate the write-zero clear from a write-one set, an event from a lost event, and real bits from reserved ones.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned NUM_EVT = 10;
  localparam int unsigned NUM_IRQ = 3;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ENA_OFS = 8;
  localparam int unsigned USB_EVT = 2;
  localparam int unsigned AUD_OFS = 14;

  function automatic int unsigned stat_pos(int unsigned e);
    return (e < USB_EVT) ? e : e + AUD_OFS;
  endfunction

  function automatic int unsigned ena_pos(int unsigned e);
    return stat_pos(e) + ENA_OFS;
  endfunction

  // line 0: usb error only; line 1: usb done + all-done; line 2: half-done
  function automatic int unsigned irq_line(int unsigned e);
    if (e == 1) return 0;
    else if ((e % 2) == 0) return 1;
    else return 2;
  endfunction

  function automatic logic [NUM_EVT-1:0] line_mask(int unsigned l);
    logic [NUM_EVT-1:0] m;
    m = '0;
    for (int unsigned e = 0; e < NUM_EVT; e++)
      if (irq_line(e) == l) m[e] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT,
  parameter int unsigned DW    = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [N_EVT-1:0] stat_o,
  output logic [N_EVT-1:0] en_o
);
  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    localparam int unsigned SP = stat_pos(g);
    localparam int unsigned EP = ena_pos(g);
    logic stat_q, en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        // event has priority over a clearing write
        if (evt_i[g])     stat_q <= 1'b1;
        else if (wr_en_i) stat_q <= stat_q & wr_data_i[SP];
        if (wr_en_i)      en_q   <= wr_data_i[EP];
      end
    end

    assign stat_o[g] = stat_q;
    assign en_o[g]   = en_q;

    a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> stat_o[g]);
    a_r4_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_o[g] && !evt_i[g]) |=> !stat_o[g]);
    a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o[g] && !wr_en_i) |=> stat_o[g]);
    a_r3_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(en_o[g]));
  end
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT,
  parameter int unsigned N_IRQ = NUM_IRQ
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] stat_i,
  input  logic [N_EVT-1:0] en_i,
  output logic [N_IRQ-1:0] irq_o
);
  logic [N_EVT-1:0] act;
  assign act = stat_i & en_i;

  for (genvar l = 0; l < N_IRQ; l++) begin : g_line
    localparam logic [N_EVT-1:0] GRP = line_mask(l);
    logic irq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |(act & GRP);
    end
    assign irq_o[l] = irq_q;

    // R10: a line stays up while any contributor is active
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(stat_i & en_i & GRP)) |=> irq_o[l]);
    a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|(stat_i & en_i & GRP)) |=> !irq_o[l]);
  end

  a_r7_line0_usb_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> $past(stat_i[1] && en_i[1]));
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT,
  parameter int unsigned N_IRQ = NUM_IRQ,
  parameter int unsigned DW    = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [N_IRQ-1:0] irq_o
);
  logic [N_EVT-1:0] stat, en;

  evt_flag_bank #(.N_EVT(N_EVT), .DW(DW)) u_flags (
    .clk_i, .rst_ni, .evt_i, .wr_en_i, .wr_data_i,
    .stat_o(stat), .en_o(en)
  );

  evt_irq_route #(.N_EVT(N_EVT), .N_IRQ(N_IRQ)) u_route (
    .clk_i, .rst_ni, .stat_i(stat), .en_i(en), .irq_o
  );

  always_comb begin
    rd_data_o = '0;
    for (int unsigned e = 0; e < N_EVT; e++) begin
      rd_data_o[stat_pos(e)] = stat[e];
      rd_data_o[ena_pos(e)]  = en[e];
    end
  end

  a_r5_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[15:10] == '0) && (rd_data_o[7:2] == '0));
endmodule

// File: tb/evt_irq_agg_tb.sv
`timescale 1ns/1ps
module evt_irq_agg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  evt_irq_agg u_dut (.*);

  typedef struct packed { logic [31:0] rd; logic [2:0] irq; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [9:0] m_stat = '0, m_en = '0;

  function automatic int sp(int e); return (e < 2) ? e : e + 14; endfunction

  function automatic logic [31:0] pack(logic [9:0] s, logic [9:0] en);
    logic [31:0] r = '0;
    for (int e = 0; e < 10; e++) begin
      r[sp(e)] = s[e];
      r[sp(e) + 8] = en[e];
    end
    return r;
  endfunction

  function automatic logic [2:0] lines(logic [9:0] a);
    logic [2:0] l;
    l[0] = a[1];                                 // R7
    l[1] = a[0] | a[2] | a[4] | a[6] | a[8];     // R8
    l[2] = a[3] | a[5] | a[7] | a[9];            // R9
    return l;
  endfunction

  task automatic step(input logic [9:0] ev, input logic wr, input logic [31:0] wd, input string tag);
    exp_t x;
    @(negedge clk_i);
    evt_i = ev; wr_en_i = wr; wr_data_i = wd;
    x.irq = lines(m_stat & m_en);
    for (int e = 0; e < 10; e++) begin
      if (ev[e]) m_stat[e] = 1'b1;
      else if (wr) m_stat[e] = m_stat[e] & wd[sp(e)];
      if (wr) m_en[e] = wd[sp(e) + 8];
    end
    x.rd = pack(m_stat, m_en);
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, '0, tag);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t x; string t;
    forever begin
      @(posedge clk_i); #5;
      if (exp_q.size() > 0) begin
        x = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (rd_data_o !== x.rd || irq_o !== x.irq) begin
          errors++;
          $display("FAIL %s rd=%h irq=%b expected rd=%h irq=%b", t, rd_data_o, irq_o, x.rd, x.irq);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (rd_data_o !== 32'h0 || irq_o !== 3'b0) begin
      errors++;
      $display("FAIL R1 rd=%h irq=%b expected rd=00000000 irq=000", rd_data_o, irq_o);
    end
    rst_ni = 1'b1;
    idle("R1");

    // R2 mapping with all masked, then R4 clear
    for (int e = 0; e < 10; e++) begin
      step(10'b1 << e, 1'b0, '0, "R2");
      idle("R2");
      step('0, 1'b1, 32'h0, "R4");
      idle("R4");
    end

    // R3 enables, R4 write-one no-op, R5 reserved ignored
    step('0, 1'b1, 32'hFFFF_FFFF, "R3");
    idle("R5");
    step('0, 1'b1, 32'h0000_FCFC, "R5");
    idle("R5");
    step('0, 1'b1, 32'hFF00_0300, "R3");

    // R7/R8/R9 per event routing
    for (int e = 0; e < 10; e++) begin
      step(10'b1 << e, 1'b0, '0, "R7_R8_R9");
      idle("R7_R8_R9");
      idle("R7_R8_R9");
      step('0, 1'b1, 32'hFF00_0300, "R10");
      idle("R10");
    end

    // R10 grouped hold: events 2 and 4 on line 1, also 0 sets line 1
    step(10'b0000010100, 1'b0, '0, "R10");
    idle("R10");
    step('0, 1'b1, 32'hFF00_0300 | (32'h1 << sp(4)), "R10");
    idle("R10");
    idle("R10");
    step('0, 1'b1, 32'hFF00_0300, "R10");
    idle("R10");
    idle("R10");

    // R10 masking alone drops line, flag kept
    step(10'b1000000000, 1'b0, '0, "R9");
    idle("R9");
    step('0, 1'b1, pack(10'b1000000000, 10'b0111111111), "R10");
    idle("R10");
    idle("R10");
    step('0, 1'b1, 32'hFF00_0300, "R4");
    idle("R4");

    // R6 collision
    step(10'b0000100010, 1'b1, 32'hFF00_0300, "R6");
    idle("R6");
    idle("R6");
    step('0, 1'b1, 32'h0, "R6");
    idle("R1");
    idle("R1");

    wait (exp_q.size() == 0);
    @(posedge clk_i); #6;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule